// File: doc/BRIEF.md
# NMI Context Save and Restore Unit

This unit sits next to a 32-bit processor core and keeps the state needed to come back from a non-maskable interrupt. When the core accepts an NMI, the unit stores a resume address and the processor status word in a dedicated pair of save registers. Bits the architecture reserves are forced to zero. At the same time it writes the NMI code into the upper half of a split cause register.

When a return-from-interrupt is executed, the unit presents the saved address and status word to the core with a valid strobe. Maskable interrupts and exceptions write only the lower half of the cause register.

The core reads all three registers through a small system-register port. Writes from that port reach the two save registers, masked to their usable bits. Writes aimed at the cause register are dropped.

Top module: `nmi_ctx_unit`

## Requirements
- R1: On a cycle with `nmi_take` high, the saved address register takes the resume address from the following edge on, with bits 31..26 cleared. With `cur_hdiv` low, the resume address is `nxt_pc`.
- R2: When `cur_hdiv` is high in an NMI cycle, the resume address is `cur_pc`, so the halfword divide runs again after return.
- R3: On NMI, the saved status register takes `cur_psw[7:0]`, and bits 31..8 read as zero.
- R4: `ret_valid` equals `reti & ~nmi_take` in the same cycle. `ret_pc` and `ret_psw` always show the current saved address and status registers.
- R5: If `nmi_take` and `reti` are high together, the NMI wins. `ret_valid` stays low and the capture of R1/R3 still happens.
- R6: On NMI, cause bits 31..16 take `nmi_code`, and bits 15..0 keep their value unless R7 applies in the same cycle.
- R7: On `exc_take`, cause bits 15..0 take `exc_code`, and bits 31..16 keep their value unless R6 applies in the same cycle.
- R8: A port write (`sr_wr` high) with `sr_sel`=2 (cause) changes no bit of the cause register.
- R9: After reset, all three registers read zero.
- R10: `sr_rdata` is combinational and selects by `sr_sel`: 0 saved address, 1 saved status, 2 cause, 3 zero. A port write with `sr_sel`=0 or 1 stores `sr_wdata` masked as in R1/R3. An NMI in the same cycle overrides that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_take | input | 1 | Core accepts an NMI this cycle |
| cur_pc | input | 32 | Address of the instruction executing |
| nxt_pc | input | 32 | Address of the following instruction |
| cur_hdiv | input | 1 | Executing instruction is a halfword divide |
| cur_psw | input | 32 | Current status word |
| nmi_code | input | 16 | NMI cause code |
| exc_take | input | 1 | Core takes an exception or maskable interrupt |
| exc_code | input | 16 | Code for that exception or interrupt |
| reti | input | 1 | Return-from-interrupt executing |
| ret_valid | output | 1 | Restore values valid for the core |
| ret_pc | output | 32 | Address to resume at |
| ret_psw | output | 32 | Status word to restore |
| sr_sel | input | 2 | System-register select |
| sr_wr | input | 1 | System-register write strobe |
| sr_wdata | input | 32 | System-register write data |
| sr_rdata | output | 32 | System-register read data |

## Verification
A wrong captured address or status shows at `ret_pc`/`ret_psw` one edge after the NMI cycle, and in the same cycle on `sr_rdata`. A cause half that updated when it should have held shows at `sr_rdata` with `sr_sel`=2 on the next cycle. A priority fault between NMI and return shows the same cycle on `ret_valid`. Random traffic that mixes NMIs, exceptions, returns and port writes is compared every cycle against a bench model. Directed cases pin down the divide rule, the cause-write drop and the reset values.

// File: rtl/nmi_ctx_pkg.sv
package nmi_ctx_pkg;
  localparam int XLEN     = 32;
  localparam int PC_KEEP  = 26;
  localparam int PSW_KEEP = 8;
  localparam int CODE_W   = XLEN / 2;

  typedef enum logic [1:0] {
    SEL_SPC   = 2'd0,
    SEL_SPSW  = 2'd1,
    SEL_CAUSE = 2'd2,
    SEL_NONE  = 2'd3
  } sr_sel_e;

  function automatic logic [XLEN-1:0] keep_low(input logic [XLEN-1:0] v, input int n);
    logic [XLEN-1:0] r;
    for (int i = 0; i < XLEN; i++) r[i] = (i < n) ? v[i] : 1'b0;
    return r;
  endfunction

  function automatic logic [XLEN-1:0] resume_addr(input logic [XLEN-1:0] here,
                                                  input logic [XLEN-1:0] after,
                                                  input logic hdiv);
    return hdiv ? here : after;
  endfunction
endpackage

// File: rtl/nmi_ctx_save.sv
module nmi_ctx_save
  import nmi_ctx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            nmi_take,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] nxt_pc,
  input  logic            cur_hdiv,
  input  logic [XLEN-1:0] cur_psw,
  input  logic            reti,
  input  logic            wr_spc,
  input  logic            wr_spsw,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] spc,
  output logic [XLEN-1:0] spsw,
  output logic            ret_valid
);
  logic [XLEN-1:0] resume;
  logic            port_pc_evt;
  logic            port_psw_evt;

  assign resume       = resume_addr(cur_pc, nxt_pc, cur_hdiv);
  assign port_pc_evt  = wr_spc  & ~nmi_take;
  assign port_psw_evt = wr_spsw & ~nmi_take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spc  <= '0;
      spsw <= '0;
    end else if (nmi_take) begin
      spc  <= keep_low(resume, PC_KEEP);
      spsw <= keep_low(cur_psw, PSW_KEEP);
    end else begin
      if (wr_spc)  spc  <= keep_low(wdata, PC_KEEP);
      if (wr_spsw) spsw <= keep_low(wdata, PSW_KEEP);
    end
  end

  assign ret_valid = reti & ~nmi_take;

  // R1
  nmi_pc_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_take && !cur_hdiv |=> spc[PC_KEEP-1:0] == $past(nxt_pc[PC_KEEP-1:0]) && spc[XLEN-1:PC_KEEP] == '0);
  // R2
  nmi_hdiv_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_take && cur_hdiv |=> spc[PC_KEEP-1:0] == $past(cur_pc[PC_KEEP-1:0]));
  // R3
  nmi_psw_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_take |=> spsw[PSW_KEEP-1:0] == $past(cur_psw[PSW_KEEP-1:0]) && spsw[XLEN-1:PSW_KEEP] == '0);
  // R5
  nmi_over_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_take |-> !ret_valid);
  // R10
  port_pc_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_pc_evt |=> spc == keep_low($past(wdata), PC_KEEP));
  // R10
  port_psw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_psw_evt |=> spsw == keep_low($past(wdata), PSW_KEEP));
endmodule

// File: rtl/nmi_ctx_cause.sv
module nmi_ctx_cause
  import nmi_ctx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_take,
  input  logic [CODE_W-1:0] nmi_code,
  input  logic              exc_take,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              cause_wr_try,
  output logic [XLEN-1:0]   cause
);
  logic [CODE_W-1:0] hi_q;
  logic [CODE_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (nmi_take) hi_q <= nmi_code;
      if (exc_take) lo_q <= exc_code;
    end
  end

  assign cause = {hi_q, lo_q};

  // R6
  nmi_keeps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_take && !exc_take |=> cause[CODE_W-1:0] == $past(cause[CODE_W-1:0]) && cause[XLEN-1:CODE_W] == $past(nmi_code));
  // R7
  exc_keeps_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take && !nmi_take |=> cause[XLEN-1:CODE_W] == $past(cause[XLEN-1:CODE_W]) && cause[CODE_W-1:0] == $past(exc_code));
  // R8
  cause_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cause_wr_try && !nmi_take && !exc_take |=> $stable(cause));
endmodule

// File: rtl/nmi_ctx_port.sv
module nmi_ctx_port
  import nmi_ctx_pkg::*;
(
  input  logic [1:0]      sr_sel,
  input  logic            sr_wr,
  input  logic [XLEN-1:0] spc,
  input  logic [XLEN-1:0] spsw,
  input  logic [XLEN-1:0] cause,
  output logic            wr_spc,
  output logic            wr_spsw,
  output logic            cause_wr_try,
  output logic [XLEN-1:0] sr_rdata
);
  sr_sel_e sel;
  assign sel = sr_sel_e'(sr_sel);

  assign wr_spc       = sr_wr && sel == SEL_SPC;
  assign wr_spsw      = sr_wr && sel == SEL_SPSW;
  assign cause_wr_try = sr_wr && sel == SEL_CAUSE;

  always_comb begin
    unique case (sel)
      SEL_SPC:   sr_rdata = spc;
      SEL_SPSW:  sr_rdata = spsw;
      SEL_CAUSE: sr_rdata = cause;
      default:   sr_rdata = '0;
    endcase
  end

  // R10
  always_comb begin
    wr_onehot_chk: assert ($onehot0({wr_spc, wr_spsw, cause_wr_try}));
  end
endmodule

// File: rtl/nmi_ctx_unit.sv
module nmi_ctx_unit
  import nmi_ctx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_take,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   nxt_pc,
  input  logic              cur_hdiv,
  input  logic [XLEN-1:0]   cur_psw,
  input  logic [CODE_W-1:0] nmi_code,
  input  logic              exc_take,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              reti,
  output logic              ret_valid,
  output logic [XLEN-1:0]   ret_pc,
  output logic [XLEN-1:0]   ret_psw,
  input  logic [1:0]        sr_sel,
  input  logic              sr_wr,
  input  logic [XLEN-1:0]   sr_wdata,
  output logic [XLEN-1:0]   sr_rdata
);
  logic [XLEN-1:0] spc;
  logic [XLEN-1:0] spsw;
  logic [XLEN-1:0] cause;
  logic            wr_spc;
  logic            wr_spsw;
  logic            cause_wr_try;

  nmi_ctx_port u_port (
    .sr_sel(sr_sel), .sr_wr(sr_wr), .spc(spc), .spsw(spsw), .cause(cause),
    .wr_spc(wr_spc), .wr_spsw(wr_spsw), .cause_wr_try(cause_wr_try), .sr_rdata(sr_rdata)
  );

  nmi_ctx_save u_save (
    .clk(clk), .rst_n(rst_n), .nmi_take(nmi_take), .cur_pc(cur_pc), .nxt_pc(nxt_pc),
    .cur_hdiv(cur_hdiv), .cur_psw(cur_psw), .reti(reti), .wr_spc(wr_spc),
    .wr_spsw(wr_spsw), .wdata(sr_wdata), .spc(spc), .spsw(spsw), .ret_valid(ret_valid)
  );

  nmi_ctx_cause u_cause (
    .clk(clk), .rst_n(rst_n), .nmi_take(nmi_take), .nmi_code(nmi_code),
    .exc_take(exc_take), .exc_code(exc_code), .cause_wr_try(cause_wr_try), .cause(cause)
  );

  assign ret_pc  = spc;
  assign ret_psw = spsw;

  // R4
  ret_follows_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> ret_pc == sr_rdata || sr_sel != 2'd0);
endmodule

// File: tb/nmi_ctx_unit_bench.sv
module nmi_ctx_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi_take = 0, cur_hdiv = 0, exc_take = 0, reti = 0, sr_wr = 0;
  logic [31:0] cur_pc = 0, nxt_pc = 0, cur_psw = 0, sr_wdata = 0;
  logic [15:0] nmi_code = 0, exc_code = 0;
  logic [1:0]  sr_sel = 0;
  logic        ret_valid;
  logic [31:0] ret_pc, ret_psw, sr_rdata;

  int checks = 0;
  int failures = 0;
  logic [31:0] m_pc = 0, m_psw = 0, m_cause = 0;

  always #2 clk = ~clk;

  nmi_ctx_unit u_nmi_ctx_unit (
    .clk(clk), .rst_n(rst_n), .nmi_take(nmi_take), .cur_pc(cur_pc), .nxt_pc(nxt_pc),
    .cur_hdiv(cur_hdiv), .cur_psw(cur_psw), .nmi_code(nmi_code), .exc_take(exc_take),
    .exc_code(exc_code), .reti(reti), .ret_valid(ret_valid), .ret_pc(ret_pc),
    .ret_psw(ret_psw), .sr_sel(sr_sel), .sr_wr(sr_wr), .sr_wdata(sr_wdata), .sr_rdata(sr_rdata)
  );

  function automatic logic [31:0] pc_mask(input logic [31:0] v);
    return v & 32'h03FF_FFFF;
  endfunction
  function automatic logic [31:0] psw_mask(input logic [31:0] v);
    return {24'h0, v[7:0]};
  endfunction
  function automatic logic [31:0] exp_read(input logic [1:0] s);
    case (s)
      2'd0: return m_pc;
      2'd1: return m_psw;
      2'd2: return m_cause;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic n, input logic hd, input logic [31:0] cp, input logic [31:0] np,
                      input logic [31:0] ps, input logic [15:0] nc, input logic e,
                      input logic [15:0] ec, input logic r, input logic [1:0] s,
                      input logic w, input logic [31:0] wd);
    @(negedge clk);
    nmi_take = n; cur_hdiv = hd; cur_pc = cp; nxt_pc = np; cur_psw = ps; nmi_code = nc;
    exc_take = e; exc_code = ec; reti = r; sr_sel = s; sr_wr = w; sr_wdata = wd;
    #1;
    chk(n ? "R5 ret_valid" : "R4 ret_valid", {31'h0, ret_valid}, {31'h0, r & ~n});
    chk("R4 ret_pc", ret_pc, m_pc);
    chk("R4 ret_psw", ret_psw, m_psw);
    chk("R10 sr_rdata", sr_rdata, exp_read(s));
    @(posedge clk);
    if (n) begin
      m_pc  = pc_mask(hd ? cp : np);
      m_psw = psw_mask(ps);
      m_cause[31:16] = nc;
    end else if (w && s == 2'd0) m_pc = pc_mask(wd);
    else if (w && s == 2'd1) m_psw = psw_mask(wd);
    if (e) m_cause[15:0] = ec;
  endtask

  task automatic idle(input logic [1:0] s);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, s, 0, 0);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R9 reset state
    for (int s = 0; s < 4; s++) begin
      @(negedge clk); sr_sel = 2'(s); #1;
      chk("R9 reset read", sr_rdata, 32'h0);
    end
    // R1 ordinary NMI uses next address, reserved bits cleared
    step(1, 0, 32'hFFFF_1000, 32'hFFFF_1004, 32'hABCD_EF5A, 16'h0010, 0, 0, 0, 2'd3, 0, 0);
    idle(2'd0);
    chk("R1 saved pc", ret_pc, 32'h03FF_1004);
    // R2 halfword divide keeps own address
    step(1, 1, 32'h0000_2220, 32'h0000_2224, 32'h0000_0033, 16'h0010, 0, 0, 0, 2'd3, 0, 0);
    idle(2'd0);
    chk("R2 hdiv saved pc", ret_pc, 32'h0000_2220);
    // R3 status mask
    step(1, 0, 0, 32'h40, 32'hFFFF_FFC3, 16'h0011, 0, 0, 0, 2'd3, 0, 0);
    idle(2'd1);
    chk("R3 saved psw", ret_psw, 32'h0000_00C3);
    // R5 NMI and return together
    step(1, 0, 0, 32'h88, 32'h5, 16'h0022, 0, 0, 1, 2'd3, 0, 0);
    idle(2'd0);
    chk("R5 capture won", ret_pc, 32'h88);
    // R7 exception only lower half
    step(0, 0, 0, 0, 0, 0, 1, 16'hBEEF, 0, 2'd3, 0, 0);
    idle(2'd2);
    chk("R7 cause", sr_rdata, 32'h0022_BEEF);
    // R6 NMI only upper half
    step(1, 0, 0, 0, 0, 16'h0123, 0, 0, 0, 2'd3, 0, 0);
    idle(2'd2);
    chk("R6 cause", sr_rdata, 32'h0123_BEEF);
    // R8 write to cause dropped
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 2'd2, 1, 32'hDEAD_DEAD);
    idle(2'd2);
    chk("R8 cause unchanged", sr_rdata, 32'h0123_BEEF);
    // R10 masked port write, then NMI beats write
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 2'd0, 1, 32'hFFFF_FFFF);
    idle(2'd0);
    chk("R10 port pc write", sr_rdata, 32'h03FF_FFFF);
    step(1, 0, 0, 32'h100, 0, 16'h1, 0, 0, 0, 2'd0, 1, 32'h7777_7777);
    idle(2'd0);
    chk("R10 nmi over write", sr_rdata, 32'h100);

    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) == 0, $urandom % 2, $urandom, $urandom, $urandom, 16'($urandom),
           ($urandom % 4) == 0, 16'($urandom), ($urandom % 3) == 0, 2'($urandom),
           ($urandom % 3) == 0, $urandom);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule